// File: doc/BRIEF.md
# Vertical Line Drop/Repeat Scaler Control

This block scales an image in the vertical direction without touching the pixel data. For every scan line presented at its input it decides how many times a downstream line store should replay that line. A count of zero drops the line, a count of one passes it through, and a larger count repeats it. A stream of such counts shrinks or stretches the page vertically.

Two modes are offered. Fractional mode adds a fixed-point factor into a phase register once per line. The count is the number of integer carries that the add produces. Factors below one therefore thin the page out, and factors between one and two stretch it. Integral mode emits every line a programmed whole number of times, up to 65,535. A page-start strobe clears the phase so that every page starts from the same alignment.

Lines are offered with a valid/ready pair. The count is returned on a second valid/acknowledge pair. A new line is refused until the downstream side acknowledges that it has finished all replays of the current line. This keeps the block in lock-step with the other per-line stages.

Top module: `vsub_scaler`

## Requirements
- R1: After reset `line_ready` is 1, `rpt_valid` is 0, `rpt_count` is 0 and the phase is zero.
- R2: When `line_valid` and `line_ready` are both 1 at a rising edge, the line is accepted. From the next cycle `rpt_valid` is 1, `rpt_count` carries that line's count, and `line_ready` is 0.
- R3: While `rpt_valid` is 1 and `rpt_ack` is 0, `rpt_count` holds its value and no further line is accepted. Changes on `scale_frac`, `rep_int` or `mode_int` during that time have no effect on the count.
- R4: When `rpt_ack` is 1 while `rpt_valid` is 1, `rpt_valid` drops and `line_ready` returns to 1 on the next cycle.
- R5: `mode_int` = 0 selects fractional mode. `scale_frac` is an unsigned 17-bit value with 16 fraction bits, so 0x10000 means 1.0. The count equals the carries out of the 16-bit phase when `scale_frac` is added to it, which gives 0, 1 or 2.
- R6: In fractional mode the phase left by one line is the start of the next line. Over a run of lines the output rate follows the factor: 0x08000 gives 0,1,0,1 from a cleared phase, and 0x18000 gives 1,2,1,2.
- R7: A one-cycle `page_start` clears the phase. If it coincides with a line acceptance, that line is computed from a zero phase.
- R8: `mode_int` = 1 selects integral mode. The count equals `rep_int` for values from 2 to 65,535.
- R9: In integral mode a `rep_int` of 0 or 1 yields a count of 2.
- R10: Lines taken in integral mode leave the fractional phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_start | input | 1 | Clears the fractional phase at the start of a page |
| mode_int | input | 1 | 0 fractional, 1 integral |
| scale_frac | input | 17 | Fractional factor, 16 fraction bits |
| rep_int | input | 16 | Integral repeat count |
| line_valid | input | 1 | A new line is offered |
| line_ready | output | 1 | Block can accept a line |
| rpt_valid | output | 1 | Count for the accepted line is presented |
| rpt_count | output | 16 | Number of times to emit the line |
| rpt_ack | input | 1 | Downstream finished all replays of the line |

## Verification
The bench drives the largest factor 0x1FFFF, where the phase sum reaches its double carry and nearly wraps. A design with too narrow a sum would report 1 where 2 is due. It lines up `page_start` with an acceptance, which catches a clear that is applied after the add rather than before it. It switches between modes in mid-page, so a design that advanced or cleared the phase on integral lines would break the fractional pattern that follows. It also holds back the acknowledge while changing the scale inputs, which exposes a count that is recomputed live or a second line that slips in early.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   typedef enum logic {
      VSC_FRAC = 1'b0,
      VSC_INTG = 1'b1
   } vsc_mode_e;

   // carries out of the phase add: 0, 1 or 2
   localparam int unsigned VSC_CARRY_W = 2;
endpackage

// File: rtl/vsc_phase_acc.sv
module vsc_phase_acc #(
   parameter int unsigned FRAC_W = 16,
   localparam int unsigned FACT_W = FRAC_W + 1,
   localparam int unsigned SUM_W  = FRAC_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [FACT_W-1:0] factor,
   output logic [1:0]        carries
);
   logic [FRAC_W-1:0] phase_q;
   logic [FRAC_W-1:0] base;
   logic [SUM_W-1:0]  sum;

   // a clear that coincides with a step applies before the add
   assign base    = clr ? '0 : phase_q;
   assign sum     = {2'b00, base} + {1'b0, factor};
   assign carries = sum[SUM_W-1:FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n)     phase_q <= '0;
      else if (step)  phase_q <= sum[FRAC_W-1:0];
      else if (clr)   phase_q <= '0;
   end

   // R7
   page_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !step |=> phase_q == '0);

   // R10
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !step |=> $stable(phase_q));
endmodule

// File: rtl/vsc_count_sel.sv
module vsc_count_sel #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MIN_REP = 2,
   parameter bit          INT_EN  = 1'b1
) (
   input  vsc_pkg::vsc_mode_e mode,
   input  logic [1:0]         carries,
   input  logic [CNT_W-1:0]   rep_req,
   output logic [CNT_W-1:0]   count
);
   logic [CNT_W-1:0] frac_cnt;
   assign frac_cnt = {{(CNT_W-2){1'b0}}, carries};

   generate
      if (INT_EN) begin : g_intg
         logic [CNT_W-1:0] intg_cnt;
         assign intg_cnt = (rep_req < CNT_W'(MIN_REP)) ? CNT_W'(MIN_REP) : rep_req;
         assign count    = (mode == vsc_pkg::VSC_INTG) ? intg_cnt : frac_cnt;
      end else begin : g_frac_only
         logic unused_ok;
         assign unused_ok = ^{mode, rep_req};
         assign count     = frac_cnt;
      end
   endgenerate
endmodule

// File: rtl/vsc_line_hs.sv
module vsc_line_hs #(
   parameter int unsigned CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_valid,
   output logic               line_ready,
   output logic               accept,
   input  logic [CNT_W-1:0]   cnt_in,
   input  vsc_pkg::vsc_mode_e mode_in,
   output vsc_pkg::vsc_mode_e mode_q,
   output logic               rpt_valid,
   output logic [CNT_W-1:0]   rpt_count,
   input  logic               rpt_ack
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign line_ready = !busy_q;
   assign accept     = line_valid && !busy_q;
   assign rpt_valid  = busy_q;
   assign rpt_count  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         mode_q <= vsc_pkg::VSC_FRAC;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= cnt_in;
         mode_q <= mode_in;
      end else if (busy_q && rpt_ack) begin
         busy_q <= 1'b0;
      end
   end

   // R2
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid && line_ready |=> rpt_valid);

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid && !rpt_ack |=> rpt_valid && $stable(rpt_count));

   // R4
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid && rpt_ack |=> !rpt_valid && line_ready);
endmodule

// File: rtl/vsub_scaler.sv
module vsub_scaler #(
   parameter int unsigned FRAC_W  = 16,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MIN_REP = 2,
   parameter bit          INT_EN  = 1'b1,
   localparam int unsigned FACT_W = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_start,
   input  logic              mode_int,
   input  logic [FACT_W-1:0] scale_frac,
   input  logic [CNT_W-1:0]  rep_int,
   input  logic              line_valid,
   output logic              line_ready,
   output logic              rpt_valid,
   output logic [CNT_W-1:0]  rpt_count,
   input  logic              rpt_ack
);
   generate
      if (FRAC_W < 1) begin : g_bad_frac
         $error("vsub_scaler: FRAC_W must be at least 1");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("vsub_scaler: CNT_W must be at least 3");
      end
      if (MIN_REP < 1 || MIN_REP >= (1 << CNT_W)) begin : g_bad_min
         $error("vsub_scaler: MIN_REP out of range");
      end
   endgenerate

   vsc_pkg::vsc_mode_e mode_sel;
   vsc_pkg::vsc_mode_e mode_q;
   logic               accept;
   logic               frac_step;
   logic [1:0]         carries;
   logic [CNT_W-1:0]   cnt_next;

   assign mode_sel  = (INT_EN && mode_int) ? vsc_pkg::VSC_INTG : vsc_pkg::VSC_FRAC;
   assign frac_step = accept && (mode_sel == vsc_pkg::VSC_FRAC);

   vsc_phase_acc #(.FRAC_W(FRAC_W)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (page_start),
      .step    (frac_step),
      .factor  (scale_frac),
      .carries (carries)
   );

   vsc_count_sel #(.CNT_W(CNT_W), .MIN_REP(MIN_REP), .INT_EN(INT_EN)) u_sel (
      .mode    (mode_sel),
      .carries (carries),
      .rep_req (rep_int),
      .count   (cnt_next)
   );

   vsc_line_hs #(.CNT_W(CNT_W)) u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_valid (line_valid),
      .line_ready (line_ready),
      .accept     (accept),
      .cnt_in     (cnt_next),
      .mode_in    (mode_sel),
      .mode_q     (mode_q),
      .rpt_valid  (rpt_valid),
      .rpt_count  (rpt_count),
      .rpt_ack    (rpt_ack)
   );

   // R5
   frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid && mode_q == vsc_pkg::VSC_FRAC |-> rpt_count <= CNT_W'(2));

   // R9
   intg_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid && mode_q == vsc_pkg::VSC_INTG |-> rpt_count >= CNT_W'(MIN_REP));
endmodule

// File: tb/tb_vsub_scaler.sv
module tb_vsub_scaler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_start = 1'b0;
   logic        mode_int = 1'b0;
   logic [16:0] scale_frac = 17'h10000;
   logic [15:0] rep_int = 16'd2;
   logic        line_valid = 1'b0;
   logic        line_ready;
   logic        rpt_valid;
   logic [15:0] rpt_count;
   logic        rpt_ack = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   vsub_scaler dut (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .mode_int(mode_int),
      .scale_frac(scale_frac), .rep_int(rep_int), .line_valid(line_valid),
      .line_ready(line_ready), .rpt_valid(rpt_valid), .rpt_count(rpt_count),
      .rpt_ack(rpt_ack)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic new_page();
      @(negedge clk);
      page_start = 1'b1;
      @(negedge clk);
      page_start = 1'b0;
   endtask

   // offer one line, check its count, acknowledge and check release
   task automatic run_line(input logic [15:0] exp, input string req);
      @(negedge clk);
      while (!line_ready) @(negedge clk);
      line_valid = 1'b1;
      @(negedge clk);
      line_valid = 1'b0;
      chk(rpt_valid == 1'b1, "R2 valid", rpt_valid, 1);
      chk(line_ready == 1'b0, "R2 ready low", line_ready, 0);
      chk(rpt_count == exp, req, rpt_count, exp);
      rpt_ack = 1'b1;
      @(negedge clk);
      rpt_ack = 1'b0;
      chk(!rpt_valid && line_ready, "R4 release", {rpt_valid, line_ready}, 2'b01);
   endtask

   task automatic t_reset();
      chk(line_ready == 1'b1, "R1 ready", line_ready, 1);
      chk(rpt_valid == 1'b0, "R1 valid", rpt_valid, 0);
      chk(rpt_count == 16'd0, "R1 count", rpt_count, 0);
      mode_int = 1'b0; scale_frac = 17'h08000;
      run_line(16'd0, "R1 phase zero after reset");
   endtask

   task automatic t_frac_patterns();
      mode_int = 1'b0;
      new_page(); scale_frac = 17'h10000;
      for (int i = 0; i < 3; i++) run_line(16'd1, "R5 unity");
      new_page(); scale_frac = 17'h08000;
      for (int i = 0; i < 4; i++) run_line((i % 2 == 1) ? 16'd1 : 16'd0, "R6 half");
      new_page(); scale_frac = 17'h18000;
      for (int i = 0; i < 4; i++) run_line((i % 2 == 1) ? 16'd2 : 16'd1, "R6 one and half");
      new_page(); scale_frac = 17'h1FFFF;
      run_line(16'd1, "R5 max first");
      run_line(16'd2, "R5 max double carry");
      run_line(16'd2, "R5 max double carry again");
      new_page(); scale_frac = 17'h00001;
      for (int i = 0; i < 3; i++) run_line(16'd0, "R5 min step");
      new_page(); scale_frac = 17'h00000;
      run_line(16'd0, "R5 zero factor");
   endtask

   task automatic t_page_clear();
      mode_int = 1'b0; scale_frac = 17'h08000;
      new_page();
      run_line(16'd0, "R7 setup");
      new_page();
      run_line(16'd0, "R7 clear alone");
      run_line(16'd1, "R7 follow");
      run_line(16'd0, "R7 setup coincident");
      @(negedge clk);
      page_start = 1'b1;
      line_valid = 1'b1;
      @(negedge clk);
      page_start = 1'b0;
      line_valid = 1'b0;
      chk(rpt_count == 16'd0, "R7 coincident clear", rpt_count, 0);
      rpt_ack = 1'b1;
      @(negedge clk);
      rpt_ack = 1'b0;
      run_line(16'd1, "R7 after coincident");
   endtask

   task automatic t_integral();
      mode_int = 1'b0; scale_frac = 17'h08000;
      new_page();
      run_line(16'd0, "R10 setup");
      mode_int = 1'b1;
      rep_int = 16'd5;     run_line(16'd5, "R8 five");
      rep_int = 16'd65535; run_line(16'd65535, "R8 max");
      rep_int = 16'd2;     run_line(16'd2, "R8 two");
      rep_int = 16'd0;     run_line(16'd2, "R9 zero floors");
      rep_int = 16'd1;     run_line(16'd2, "R9 one floors");
      mode_int = 1'b0;
      run_line(16'd1, "R10 phase kept");
   endtask

   task automatic t_hold();
      mode_int = 1'b0; scale_frac = 17'h10000;
      new_page();
      @(negedge clk);
      line_valid = 1'b1;
      @(negedge clk);
      scale_frac = 17'h00000;
      mode_int = 1'b1;
      rep_int = 16'd9;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(rpt_valid && rpt_count == 16'd1, "R3 held", rpt_count, 1);
         chk(line_ready == 1'b0, "R3 no accept", line_ready, 0);
      end
      line_valid = 1'b0;
      rpt_ack = 1'b1;
      @(negedge clk);
      rpt_ack = 1'b0;
      @(negedge clk);
      chk(!rpt_valid, "R3 no extra line", rpt_valid, 0);
      mode_int = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frac_patterns();
      t_page_clear();
      t_integral();
      t_hold();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule